// File: doc/BRIEF.md
# Three-Component Gamma Lookup Stream Stage

This block sits in a video pipeline and rewrites every colour component of every pixel through a lookup table of its own. A beat on the input stream carries `PIX` pixels of three `COMP_W`-bit components each. Every component lane is translated through the table for its position, and the beat leaves on the output stream in the same layout. The frame-start flag (TUSER bit 0) and the line-end flag (TLAST) travel with their pixel. Each table has `2^COMP_W` entries of `COMP_W` bits. Its contents are computed by a fixed curve chosen per table: table 0 inverts, table 1 squares, and table 2 applies a gain of two with clipping. A separate read port returns any entry of any table, so the curves can be inspected.

The input side has a two-entry skid buffer run by a three-state machine. The states are `SKID_EMPTY`, `SKID_HALF` and `SKID_FULL`. Its transitions are:
- fill: `SKID_EMPTY` to `SKID_HALF`, on a push.
- grow: `SKID_HALF` to `SKID_FULL`, on a push without a pop.
- drain: `SKID_HALF` to `SKID_EMPTY`, on a pop without a push.
- flow: `SKID_HALF` stays in `SKID_HALF`, on a push and a pop together.
- release: `SKID_FULL` to `SKID_HALF`, on a pop.

Input ready is decoded from the registered state, so it is ready in every state except `SKID_FULL`. Behind the buffer sit two pipeline stages. The first is the synchronous table read and the second is the output register. Both advance together whenever the output register is empty or is being accepted.

Top module: `gamma_xform_top`

## Requirements
- R1: Component 0 of every pixel (bits `[3W*p +: W]`) leaves as `2^W-1-x`, where x is its input value.
- R2: Component 1 of every pixel (bits `[3W*p+W +: W]`) leaves as `floor(x*x / 2^W)`.
- R3: Component 2 of every pixel (bits `[3W*p+2W +: W]`) leaves as `2x` when x < 2^(W-1), and as `2^W-1` otherwise.
- R4: Pixel p occupies bits `[3W*p +: 3W]` of the data bus, and each pixel lane uses the same three tables independently of the other lanes.
- R5: The data bus is `ceil(3*W*PIX/8)*8` bits wide. The pad bits above bit `3*W*PIX-1` read zero on the output, and input pad bits have no effect on any output.
- R6: `m_tuser` and `m_tlast` of each output beat equal `s_tuser` and `s_tlast` of the input beat that produced it.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values into the next cycle.
- R8: With `m_tready` held low, the block accepts at most four beats and then holds `s_tready` low. No accepted beat is lost.
- R9: Output beats come out in acceptance order, each exactly once. `m_tvalid` is never high with no beat in flight.
- R10: While `rst_n` is low on a rising edge, all in-flight beats are discarded. After reset, `m_tvalid` is low and `s_tready` is high.
- R11: The read port returns table `dbg_sel` (0, 1 or 2) at address `dbg_addr` one clock edge after it is presented. A `dbg_sel` value of 3 returns zero.
- R12: A beat accepted on edge E is first presented on the output after edge E+2. With both valid and ready held high, one beat passes every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | ceil(3*COMP_W*PIX/8)*8 | Input pixels, zero-padded to bytes |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can take an input beat |
| s_tuser | input | 1 | Input frame-start flag |
| s_tlast | input | 1 | Input line-end flag |
| m_tdata | output | ceil(3*COMP_W*PIX/8)*8 | Transformed pixels, pad bits zero |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the output beat |
| m_tuser | output | 1 | Output frame-start flag |
| m_tlast | output | 1 | Output line-end flag |
| dbg_sel | input | 2 | Table select for the read port |
| dbg_addr | input | COMP_W | Table entry address for the read port |
| dbg_data | output | COMP_W | Table entry read back |

## Verification
The bench uses a small configuration: 6-bit components and two pixels per beat, so the bus carries four pad bits. It first runs a sweep in which each pixel lane and each component takes all 64 codes, with different offsets per lane and per component. A mistake in a curve, a swapped lane or a swapped component therefore shows up as a value mismatch. The sweep runs with no gaps and no backpressure, which pins down the two-edge latency and the one-beat-per-cycle rate. A second stream uses pseudo-random input gaps and output stalls, which tests ordering and the flags. A held-stall pattern counts how many beats are taken before input ready drops and checks that the stalled output does not move. A reset issued mid-stream, and a sweep of every address through the read port, cover the remaining rules.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    typedef enum logic [1:0] {
        CURVE_INVERT = 2'd0,
        CURVE_SQUARE = 2'd1,
        CURVE_GAIN2  = 2'd2
    } curve_e;

    typedef enum logic [1:0] {
        SKID_EMPTY = 2'd0,
        SKID_HALF  = 2'd1,
        SKID_FULL  = 2'd2
    } skid_state_e;

    // Bus width in bits: three components per pixel, rounded up to whole bytes.
    function automatic int bus_bits(input int comp_w, input int pix);
        return ((3 * comp_w * pix + 7) / 8) * 8;
    endfunction

    // Curve that serves component position c.
    function automatic curve_e curve_of(input int c);
        if (c == 0) return CURVE_INVERT;
        if (c == 1) return CURVE_SQUARE;
        return CURVE_GAIN2;
    endfunction

endpackage

// File: rtl/gamma_lut_rom.sv
module gamma_lut_rom
    import gamma_pkg::*;
#(
    parameter int     W     = 8,
    parameter curve_e CURVE = CURVE_INVERT
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] addr,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] CODE_MAX = '1;

    logic [W-1:0] entry;

    generate
        if (CURVE == CURVE_INVERT) begin : g_invert
            assign entry = CODE_MAX - addr;
        end else if (CURVE == CURVE_SQUARE) begin : g_square
            logic [2*W-1:0] wide;
            assign wide  = {{W{1'b0}}, addr} * {{W{1'b0}}, addr};
            assign entry = wide[2*W-1:W];
        end else begin : g_gain2
            assign entry = addr[W-1] ? CODE_MAX : {addr[W-2:0], 1'b0};
        end
    endgenerate

    // Synchronous read: the entry appears one edge after the address.
    always_ff @(posedge clk) begin
        if (en) begin
            q <= entry;
        end
    end

endmodule

// File: rtl/gamma_skid.sv
module gamma_skid
    import gamma_pkg::*;
#(
    parameter int PW = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] in_pl,
    output logic          head_valid,
    output logic [PW-1:0] head_pl,
    input  logic          pop
);

    skid_state_e  state_q, state_d;
    logic [PW-1:0] spare_q;
    logic          push;

    assign push = in_valid && in_ready;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SKID_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: fill, grow, drain, flow, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SKID_EMPTY: if (push)              state_d = SKID_HALF;
            SKID_HALF: begin
                if (push && !pop)              state_d = SKID_FULL;
                else if (!push && pop)         state_d = SKID_EMPTY;
            end
            SKID_FULL:  if (pop)               state_d = SKID_HALF;
            default:                           state_d = SKID_EMPTY;
        endcase
    end

    // Storage moves.
    always_ff @(posedge clk) begin
        unique case (state_q)
            SKID_EMPTY: if (push) head_pl <= in_pl;
            SKID_HALF: begin
                if (push && pop)       head_pl <= in_pl;
                else if (push)         spare_q <= in_pl;
            end
            SKID_FULL:  if (pop)  head_pl <= spare_q;
            default: ;
        endcase
    end

    // Outputs decoded from the registered state.
    always_comb begin
        in_ready   = 1'b0;
        head_valid = 1'b0;
        unique case (state_q)
            SKID_EMPTY: begin in_ready = 1'b1; head_valid = 1'b0; end
            SKID_HALF:  begin in_ready = 1'b1; head_valid = 1'b1; end
            SKID_FULL:  begin in_ready = 1'b0; head_valid = 1'b1; end
            default:    begin in_ready = 1'b0; head_valid = 1'b0; end
        endcase
    end

endmodule

// File: rtl/gamma_xform_top.sv
module gamma_xform_top
    import gamma_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int PIX    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [bus_bits(COMP_W, PIX)-1:0]   s_tdata,
    input  logic                               s_tvalid,
    output logic                               s_tready,
    input  logic                               s_tuser,
    input  logic                               s_tlast,
    output logic [bus_bits(COMP_W, PIX)-1:0]   m_tdata,
    output logic                               m_tvalid,
    input  logic                               m_tready,
    output logic                               m_tuser,
    output logic                               m_tlast,
    input  logic [1:0]                         dbg_sel,
    input  logic [COMP_W-1:0]                  dbg_addr,
    output logic [COMP_W-1:0]                  dbg_data
);

    localparam int PIX_BITS = 3 * COMP_W;
    localparam int DATA_W   = PIX_BITS * PIX;
    localparam int BUS_W    = bus_bits(COMP_W, PIX);
    localparam int PL_W     = DATA_W + 2;
    localparam int N_COMP   = 3;

    // Input pad bits take no part in the transform.
    logic in_bits_unused;
    assign in_bits_unused = ^s_tdata;

    logic              head_valid;
    logic [PL_W-1:0]   head_pl;
    logic              advance;
    logic              pop;

    gamma_skid #(.PW(PL_W)) u_skid (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (s_tvalid),
        .in_ready   (s_tready),
        .in_pl      ({s_tlast, s_tuser, s_tdata[DATA_W-1:0]}),
        .head_valid (head_valid),
        .head_pl    (head_pl),
        .pop        (pop)
    );

    logic              v1_q, v2_q;
    logic [1:0]        sb1_q, sb2_q;
    logic [DATA_W-1:0] lut_q;
    logic [DATA_W-1:0] d2_q;

    // The whole pipeline moves when the output register is free or draining.
    assign advance = !v2_q || m_tready;
    assign pop     = advance && head_valid;

    // Stage 1 data: one table read per component per pixel lane.
    generate
        for (genvar p = 0; p < PIX; p++) begin : g_lane
            for (genvar c = 0; c < N_COMP; c++) begin : g_comp
                gamma_lut_rom #(.W(COMP_W), .CURVE(curve_of(c))) u_rom (
                    .clk  (clk),
                    .en   (advance),
                    .addr (head_pl[(p*N_COMP + c)*COMP_W +: COMP_W]),
                    .q    (lut_q[(p*N_COMP + c)*COMP_W +: COMP_W])
                );
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else if (advance) begin
            v1_q <= pop;
            v2_q <= v1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (advance) begin
            sb1_q <= head_pl[PL_W-1:DATA_W];
            sb2_q <= sb1_q;
            d2_q  <= lut_q;
        end
    end

    assign m_tvalid = v2_q;
    assign m_tdata  = BUS_W'(d2_q);
    assign m_tuser  = sb2_q[0];
    assign m_tlast  = sb2_q[1];

    // Read-only inspection port: a dedicated read copy of each table.
    logic [COMP_W-1:0] dbg_q [N_COMP];
    logic [1:0]        dbg_sel_q;

    generate
        for (genvar c = 0; c < N_COMP; c++) begin : g_dbg
            gamma_lut_rom #(.W(COMP_W), .CURVE(curve_of(c))) u_rom (
                .clk  (clk),
                .en   (1'b1),
                .addr (dbg_addr),
                .q    (dbg_q[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        dbg_sel_q <= dbg_sel;
    end

    always_comb begin
        unique case (dbg_sel_q)
            2'd0:    dbg_data = dbg_q[0];
            2'd1:    dbg_data = dbg_q[1];
            2'd2:    dbg_data = dbg_q[2];
            default: dbg_data = '0;
        endcase
    end

endmodule

// File: rtl/gamma_xform_checks.sv
module gamma_xform_checks #(
    parameter int COMP_W = 8,
    parameter int PIX    = 2
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         s_tvalid,
    input logic                                         s_tready,
    input logic                                         m_tvalid,
    input logic                                         m_tready,
    input logic [gamma_pkg::bus_bits(COMP_W, PIX)-1:0]  m_tdata,
    input logic                                         m_tuser,
    input logic                                         m_tlast
);

    localparam int DATA_W = 3 * COMP_W * PIX;
    localparam int BUS_W  = gamma_pkg::bus_bits(COMP_W, PIX);

    logic [2:0] occ_q;

    // Beats accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + 3'((s_tvalid && s_tready) ? 1 : 0)
                           - 3'((m_tvalid && m_tready) ? 1 : 0);
        end
    end

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tuser) && $stable(m_tlast)));

    assert_occ_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 3'd4);

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == 3'd4) |-> !s_tready);

    assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == 3'd0) |-> !m_tvalid);

    assert_reset_idle_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> (!m_tvalid && s_tready));

    generate
        if (BUS_W > DATA_W) begin : g_pad
            assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                m_tvalid |-> (m_tdata[BUS_W-1:DATA_W] == '0));
        end else begin : g_nopad
            logic data_unused;
            assign data_unused = ^m_tdata;
        end
    endgenerate

endmodule

bind gamma_xform_top gamma_xform_checks #(.COMP_W(COMP_W), .PIX(PIX)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast)
);

// File: tb/gamma_xform_top_tb.sv
`timescale 1ns/1ps
module gamma_xform_top_tb;

    localparam int W    = 6;
    localparam int P    = 2;
    localparam int DW   = 3 * W * P;
    localparam int BW   = ((DW + 7) / 8) * 8;
    localparam int TOPV = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
    logic          s_tready;
    logic [BW-1:0] m_tdata;
    logic          m_tvalid, m_tuser, m_tlast;
    logic          m_tready = 1'b0;
    logic [1:0]    dbg_sel = '0;
    logic [W-1:0]  dbg_addr = '0;
    logic [W-1:0]  dbg_data;

    always #2.5 clk = ~clk;

    gamma_xform_top #(.COMP_W(W), .PIX(P)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast),
        .dbg_sel(dbg_sel), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [DW+1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int ref_curve(input int c, input int x);
        if (c == 0) return TOPV - x;
        if (c == 1) return (x * x) / (1 << W);
        return (x >= (1 << (W - 1))) ? TOPV : 2 * x;
    endfunction

    function automatic logic [DW+1:0] expect_of(input logic [BW-1:0] d,
                                                 input logic u, input logic l);
        logic [DW+1:0] r;
        r = '0;
        for (int p = 0; p < P; p++)
            for (int c = 0; c < 3; c++)
                r[(3*p + c)*W +: W] = W'(ref_curve(c, int'(d[(3*p + c)*W +: W])));
        r[DW]   = u;
        r[DW+1] = l;
        return r;
    endfunction

    function automatic string comp_req(input int c);
        if (c == 0) return "R1/R4";
        if (c == 1) return "R2/R4";
        return "R3/R4";
    endfunction

    task automatic check_out();
        logic [DW+1:0] e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "output beat with nothing in flight", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        for (int p = 0; p < P; p++)
            for (int c = 0; c < 3; c++)
                chk(m_tdata[(3*p + c)*W +: W] == e[(3*p + c)*W +: W], comp_req(c),
                    $sformatf("pixel %0d comp %0d", p, c),
                    m_tdata[(3*p + c)*W +: W], e[(3*p + c)*W +: W]);
        chk(m_tdata[BW-1:DW] == '0, "R5", "output pad bits", m_tdata[BW-1:DW], 0);
        chk(m_tuser == e[DW], "R6", "tuser", m_tuser, e[DW]);
        chk(m_tlast == e[DW+1], "R6", "tlast", m_tlast, e[DW+1]);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Runs nbeats through the block; rnd adds gaps and stalls; hold keeps
    // m_tready low for the first hold cycles.
    task automatic stream(input int nbeats, input bit rnd, input int hold,
                          output int first_acc, output int first_out,
                          output int last_out);
        int  sent = 0;
        int  acc_hold = 0;
        int  it = 0;
        bit  pend = 1'b0;
        logic [BW-1:0] snap = '0;
        first_acc = -1; first_out = -1; last_out = -1;
        while ((sent < nbeats || pend || exp_q.size() > 0) && it < 20000) begin
            if (!pend && sent < nbeats && (!rnd || lfsr[0])) begin
                for (int p = 0; p < P; p++)
                    for (int c = 0; c < 3; c++)
                        s_tdata[(3*p + c)*W +: W] =
                            W'((sent * (rnd ? 5 : 1) + 21*c + 11*p) % (1 << W));
                s_tdata[BW-1:DW] = (BW - DW)'(sent ^ 10);
                s_tuser = (sent == 0);
                s_tlast = (sent % 8 == 7);
                pend = 1'b1;
            end
            s_tvalid = pend;
            if (it < hold)      m_tready = 1'b0;
            else if (rnd)       m_tready = (lfsr[3:2] != 2'b00);
            else                m_tready = 1'b1;
            if (hold > 0 && it == hold - 3) snap = m_tdata;
            if (hold > 0 && it == hold) begin
                chk(acc_hold == 4, "R8", "beats taken while stalled", acc_hold, 4);
                chk(s_tready == 1'b0, "R8", "input ready while stalled", s_tready, 0);
                chk(m_tvalid == 1'b1 && m_tdata == snap, "R7", "stalled output held",
                    m_tdata, snap);
            end
            if (pend && s_tready) begin
                exp_q.push_back(expect_of(s_tdata, s_tuser, s_tlast));
                if (first_acc < 0) first_acc = cyc;
                if (it < hold) acc_hold++;
                pend = 1'b0;
                sent++;
            end
            if (m_tvalid && m_tready) begin
                check_out();
                if (first_out < 0) first_out = cyc;
                last_out = cyc;
            end
            step_lfsr();
            @(negedge clk);
            cyc++;
            it++;
        end
        s_tvalid = 1'b0;
        m_tready = 1'b0;
        chk(exp_q.size() == 0, "R9", "beats left undelivered", exp_q.size(), 0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL R9 watchdog: actual run unfinished, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int fa, fo, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "valid after reset", m_tvalid, 0);
        chk(s_tready == 1'b1, "R10", "ready after reset", s_tready, 1);

        // Full-rate sweep over every code in every lane and component.
        stream(64, 1'b0, 0, fa, fo, lo);
        chk(fo - fa == 3, "R12", "latency in negedges from accept", fo - fa, 3);
        chk(lo - fo == 63, "R12", "cycles spanned by 64 beats", lo - fo, 63);

        // Random gaps and stalls.
        stream(300, 1'b1, 0, fa, fo, lo);

        // Held stall from an empty pipeline, then release.
        stream(12, 1'b0, 10, fa, fo, lo);

        // Reset in the middle of a stalled stream.
        s_tdata = '0; s_tvalid = 1'b1; m_tready = 1'b0;
        repeat (6) @(negedge clk);
        s_tvalid = 1'b0;
        rst_n = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "valid after mid-stream reset", m_tvalid, 0);
        chk(s_tready == 1'b1, "R10", "ready after mid-stream reset", s_tready, 1);
        stream(20, 1'b1, 0, fa, fo, lo);

        // Read port sweep over all tables and addresses.
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                dbg_sel  = 2'(s);
                dbg_addr = W'(a);
                @(negedge clk);
                chk(dbg_data == W'((s == 3) ? 0 : ref_curve(s, a)), "R11",
                    $sformatf("table %0d addr %0d", s, a), dbg_data,
                    (s == 3) ? 0 : ref_curve(s, a));
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule